// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a simple synchronous host request port to an external asynchronous static RAM that has a fixed 16-bit data bus. The host issues one transfer at a time. Each transfer carries a byte address, a write flag, a size code for byte, halfword or word, and write data, and uses a valid/ready handshake. A read returns its data together with a one-cycle done pulse.

Host transfers narrower than the memory use the byte-lane strobes. A halfword transfer maps onto exactly one memory access. A word transfer becomes two memory accesses back to back: the low halfword goes first and the high halfword follows. Every memory access runs through four phases: address setup, address hold, data, and a turnaround gap. The length of each phase comes from configuration inputs, and the controller captures those inputs when it accepts a request. Suggested settings are setup 3, hold 0, data 6 and turnaround 1.

Top module: `sram_bridge`

## Requirements
- R1: Size codes are 0 for byte, 1 for halfword, and 2 or 3 for word. A byte or halfword request makes one memory access and a word request makes two. The done pulse arrives N cycles after the accepting clock edge, where N = accesses × (setup + hold + max(data,1) + turn).
- R2: The memory word address is host address bits [18:1]. In a word transfer, the first access uses that address and carries host bits [15:0]. The second access uses that address plus one and carries bits [31:16]. Only one done pulse is raised, and only after the second access.
- R3: On a byte write, host address bit 0 selects the lane. A value of 0 drives `mem_lb_n` low only, and a value of 1 drives `mem_ub_n` low only. The byte appears on both halves of the bus, and the other byte in the memory word keeps its contents.
- R4: Halfword and word writes hold both lane strobes low during the access.
- R5: On any read, both lane strobes are low. `mem_oe_n` is low only during the data phase, `mem_we_n` stays high, and the controller does not drive the bus. The full 16-bit word is captured on the last data-phase clock. A byte read returns the addressed lane zero-extended in bits [7:0]. A halfword read returns the word in bits [15:0]. A word read returns both accesses assembled into 32 bits.
- R6: The setup, hold, data and turnaround lengths are taken from `cfg_*` when a request is accepted. A data length of 0 counts as 1. On a write, `mem_we_n` is low for exactly max(data,1) cycles per access.
- R7: `mem_ce_n` is low throughout the setup, hold and data phases. It is high during every turnaround cycle and whenever the controller is idle.
- R8: `req_ready` is high only when the controller is idle. It falls after a request is accepted and rises in the same cycle as `rsp_done`. `rsp_done` lasts exactly one cycle.
- R9: During reset, all active-low memory controls are high and the bus is released. `req_ready` is high, `rsp_done` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 19 | Host byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Read data, held until next request |
| rsp_done | output | 1 | One-cycle completion pulse |
| cfg_setup | input | 4 | Address setup cycles |
| cfg_hold | input | 4 | Address hold cycles |
| cfg_data | input | 4 | Data phase cycles (0 acts as 1) |
| cfg_turn | input | 4 | Turnaround cycles |
| mem_addr | output | 18 | Memory word address |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane strobe, active low |
| mem_ub_n | output | 1 | High byte lane strobe, active low |

## Verification
The controller accepts a request on the first rising edge at which `req_valid` is sampled high while it is idle. `rsp_done` is then due exactly N cycles later, with N given by R1. The bench samples on falling edges. It counts the busy cycles between acceptance and the done pulse and compares that count with N. Over the same window it counts the cycles in which write enable is low, output enable is low, chip select is high and ready is high, and it records the lane pattern and the address seen in the first and last strobed cycle. Read data is compared in the done cycle, because the value was captured on the last data-phase edge. The checks repeat for three timing configurations, one of which uses a zero data length.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WRSV = 2'd3
   } xfer_size_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_HOLD  = 3'd2,
      PH_DATA  = 3'd3,
      PH_TURN  = 3'd4
   } phase_e;

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
   import sram_bridge_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             two_acc,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] hold_len,
   input  logic [CNT_W-1:0] data_len,
   input  logic [CNT_W-1:0] turn_len,
   output phase_e           phase,
   output logic             cnt_zero,
   output logic             second,
   output logic             fin
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   typedef struct packed {
      phase_e           ph;
      logic [CNT_W-1:0] n;
   } step_t;

   logic [CNT_W-1:0] setup_q, hold_q, dlen_q, turn_q, cnt;
   logic             two_q;
   logic [CNT_W-1:0] dlen_in;
   step_t            nxt;
   logic             nxt_second, nxt_fin, end_acc;

   function automatic step_t enter_access(input logic [CNT_W-1:0] s,
                                          input logic [CNT_W-1:0] h,
                                          input logic [CNT_W-1:0] dl);
      step_t r;
      if (s != '0)      r = '{ph: PH_SETUP, n: s - ONE};
      else if (h != '0) r = '{ph: PH_HOLD,  n: h - ONE};
      else              r = '{ph: PH_DATA,  n: dl - ONE};
      return r;
   endfunction

   assign dlen_in  = (data_len == '0) ? ONE : data_len;
   assign cnt_zero = (cnt == '0);

   always_comb begin
      nxt        = '{ph: phase, n: cnt};
      nxt_second = second;
      nxt_fin    = 1'b0;
      end_acc    = 1'b0;
      case (phase)
         PH_IDLE: if (start) begin
            nxt        = enter_access(setup_len, hold_len, dlen_in);
            nxt_second = 1'b0;
         end
         PH_SETUP: if (cnt_zero) begin
            if (hold_q != '0) nxt = '{ph: PH_HOLD, n: hold_q - ONE};
            else              nxt = '{ph: PH_DATA, n: dlen_q - ONE};
         end else nxt.n = cnt - ONE;
         PH_HOLD: if (cnt_zero) nxt = '{ph: PH_DATA, n: dlen_q - ONE};
                  else          nxt.n = cnt - ONE;
         PH_DATA: if (cnt_zero) begin
            if (turn_q != '0) nxt = '{ph: PH_TURN, n: turn_q - ONE};
            else              end_acc = 1'b1;
         end else nxt.n = cnt - ONE;
         PH_TURN: if (cnt_zero) end_acc = 1'b1;
                  else          nxt.n = cnt - ONE;
         default: nxt = '{ph: PH_IDLE, n: '0};
      endcase
      if (end_acc) begin
         if (two_q && !second) begin
            nxt        = enter_access(setup_q, hold_q, dlen_q);
            nxt_second = 1'b1;
         end else begin
            nxt     = '{ph: PH_IDLE, n: '0};
            nxt_fin = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         second  <= 1'b0;
         fin     <= 1'b0;
         two_q   <= 1'b0;
         setup_q <= '0;
         hold_q  <= '0;
         dlen_q  <= ONE;
         turn_q  <= '0;
      end else begin
         phase  <= nxt.ph;
         cnt    <= nxt.n;
         second <= nxt_second;
         fin    <= nxt_fin;
         if (phase == PH_IDLE && start) begin
            two_q   <= two_acc;
            setup_q <= setup_len;
            hold_q  <= hold_len;
            dlen_q  <= dlen_in;
            turn_q  <= turn_len;
         end
      end
   end

   // R8: completion is only signalled on return to idle
   p_fin_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> phase == PH_IDLE);
   // R2: the second access is only started for a split transfer
   p_second_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (second && phase != PH_IDLE) |-> two_q);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map
   import sram_bridge_pkg::*;
#(
   parameter int MEM_DW  = 16,
   parameter int HOST_DW = 32
) (
   input  xfer_size_e          size,
   input  logic                sel,
   input  logic                second,
   input  logic [HOST_DW-1:0]  wdata,
   input  logic [MEM_DW-1:0]   rd_dq,
   input  logic [HOST_DW-1:0]  rd_prev,
   output logic [MEM_DW/8-1:0] wr_lane_n,
   output logic [MEM_DW-1:0]   wr_dq,
   output logic [HOST_DW-1:0]  rd_next
);

   localparam int LANES = MEM_DW / 8;
   logic is_byte;
   assign is_byte = (size == SZ_BYTE);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam bit LSEL = (i % 2) == 1;
      assign wr_lane_n[i]   = is_byte ? (sel != LSEL) : 1'b0;
      assign wr_dq[8*i +: 8] = is_byte ? wdata[7:0] :
                               (second ? wdata[MEM_DW + 8*i +: 8] : wdata[8*i +: 8]);
   end

   always_comb begin
      case (size)
         SZ_BYTE: rd_next = HOST_DW'(sel ? rd_dq[MEM_DW-1 -: 8] : rd_dq[7:0]);
         SZ_HALF: rd_next = HOST_DW'(rd_dq);
         default: rd_next = second ? {rd_dq, rd_prev[MEM_DW-1:0]} : HOST_DW'(rd_dq);
      endcase
   end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
   import sram_bridge_pkg::*;
#(
   parameter int MEM_AW  = 18,
   parameter int MEM_DW  = 16,
   parameter int HOST_DW = 32,
   parameter int CNT_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [1:0]           req_size,
   input  logic [MEM_AW:0]      req_addr,
   input  logic [HOST_DW-1:0]   req_wdata,
   output logic [HOST_DW-1:0]   rsp_rdata,
   output logic                 rsp_done,
   input  logic [CNT_W-1:0]     cfg_setup,
   input  logic [CNT_W-1:0]     cfg_hold,
   input  logic [CNT_W-1:0]     cfg_data,
   input  logic [CNT_W-1:0]     cfg_turn,
   output logic [MEM_AW-1:0]    mem_addr,
   inout  wire  [MEM_DW-1:0]    mem_dq,
   output logic                 mem_ce_n,
   output logic                 mem_oe_n,
   output logic                 mem_we_n,
   output logic                 mem_lb_n,
   output logic                 mem_ub_n
);

   localparam int LANES   = MEM_DW / 8;
   localparam int HOST_AW = MEM_AW + 1;

   if (MEM_DW != 16) begin : g_bad_mem_dw
      $error("sram_bridge: memory data width must be 16");
   end
   if (HOST_DW != 2 * MEM_DW) begin : g_bad_host_dw
      $error("sram_bridge: host width must be twice the memory width");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("sram_bridge: phase counter needs at least 2 bits");
   end

   phase_e               phase;
   logic                 cnt_zero, second, fin, start, active, drive;
   logic [HOST_AW-1:0]   addr_q;
   logic                 wr_q;
   xfer_size_e           size_q;
   logic [HOST_DW-1:0]   wdata_q, rdata_q, rd_next;
   logic [LANES-1:0]     wr_lane_n, lane_n;
   logic [MEM_DW-1:0]    wr_dq;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;

   sram_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .two_acc   (req_size[1]),
      .setup_len (cfg_setup),
      .hold_len  (cfg_hold),
      .data_len  (cfg_data),
      .turn_len  (cfg_turn),
      .phase     (phase),
      .cnt_zero  (cnt_zero),
      .second    (second),
      .fin       (fin)
   );

   sram_lane_map #(.MEM_DW(MEM_DW), .HOST_DW(HOST_DW)) u_lane (
      .size      (size_q),
      .sel       (addr_q[0]),
      .second    (second),
      .wdata     (wdata_q),
      .rd_dq     (mem_dq),
      .rd_prev   (rdata_q),
      .wr_lane_n (wr_lane_n),
      .wr_dq     (wr_dq),
      .rd_next   (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wr_q    <= 1'b0;
         size_q  <= SZ_BYTE;
         wdata_q <= '0;
         rdata_q <= '0;
      end else if (start) begin
         addr_q  <= req_addr;
         wr_q    <= req_write;
         size_q  <= xfer_size_e'(req_size);
         wdata_q <= req_wdata;
         rdata_q <= '0;
      end else if (phase == PH_DATA && cnt_zero && !wr_q) begin
         rdata_q <= rd_next;
      end
   end

   assign active    = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);
   assign drive     = active && wr_q;
   assign lane_n    = active ? (wr_q ? wr_lane_n : '0) : '1;
   assign mem_ce_n  = !active;
   assign mem_oe_n  = !(phase == PH_DATA && !wr_q);
   assign mem_we_n  = !(phase == PH_DATA && wr_q);
   assign mem_lb_n  = lane_n[0];
   assign mem_ub_n  = lane_n[LANES-1];
   assign mem_addr  = addr_q[HOST_AW-1:1] + MEM_AW'(second);
   assign mem_dq    = drive ? wr_dq : 'z;
   assign rsp_rdata = rdata_q;
   assign rsp_done  = fin;

   // R5: never output and write enable together
   p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   // R5: reads strobe both lanes
   p_read_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_lb_n && !mem_ub_n));
   // R3: byte write strobes exactly one lane
   p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && size_q == SZ_BYTE) |-> $countones({mem_ub_n, mem_lb_n}) == 1);
   // R7: write enable only inside chip select
   p_we_in_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);
   // R8: ready drops after acceptance
   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R8: done only when ready
   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

endmodule

// File: tb/sram_bridge_test.sv
module sram_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [18:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_done;
   logic [3:0]  cfg_setup = 4'd3, cfg_hold = 4'd0, cfg_data = 4'd6, cfg_turn = 4'd1;
   logic [17:0] mem_addr;
   wire  [15:0] mem_dq;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

   int checks = 0;
   int errors = 0;
   logic [15:0] mem [0:63];
   logic [15:0] ref_m [0:63];

   always #10 clk = ~clk;

   sram_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_data(cfg_data), .cfg_turn(cfg_turn),
      .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
   );

   assign mem_dq = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr[5:0]] : 16'hzzzz;

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n) begin
         if (!mem_lb_n) mem[mem_addr[5:0]][7:0]  <= mem_dq[7:0];
         if (!mem_ub_n) mem[mem_addr[5:0]][15:8] <= mem_dq[15:8];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [1:0] sz, input logic [18:0] a, input logic [31:0] wd);
      int acc, dl, expn, n, we_lo, oe_lo, ce_hi, rdy_hi, lane_bad;
      logic [17:0] first_a, last_a;
      logic [1:0]  exp_lanes;
      logic [31:0] exp_rd;
      bit seen;
      acc  = sz[1] ? 2 : 1;
      dl   = (cfg_data == 0) ? 1 : int'(cfg_data);
      expn = acc * (int'(cfg_setup) + int'(cfg_hold) + dl + int'(cfg_turn));
      exp_lanes = (wr && sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
      @(negedge clk);
      chk(!rsp_done, "R8 done width", 32'(rsp_done), 0);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0; we_lo = 0; oe_lo = 0; ce_hi = 0; rdy_hi = 0; lane_bad = 0; seen = 0;
      first_a = '0; last_a = '0;
      while (!rsp_done && n < 1000) begin
         n++;
         if (!mem_we_n) we_lo++;
         if (!mem_oe_n) oe_lo++;
         if (mem_ce_n) ce_hi++;
         if (req_ready) rdy_hi++;
         if (!mem_we_n || !mem_oe_n) begin
            if ({mem_ub_n, mem_lb_n} != exp_lanes) lane_bad++;
            if (!seen) first_a = mem_addr;
            seen = 1;
            last_a = mem_addr;
         end
         @(negedge clk);
      end
      chk(n == expn, "R1 latency", n, expn);
      if (wr) begin
         chk(we_lo == acc * dl, "R6 we cycles", we_lo, acc * dl);
         chk(lane_bad == 0, (sz == 2'd0) ? "R3 lanes" : "R4 lanes", lane_bad, 0);
         if (sz == 2'd0) begin
            if (a[0]) ref_m[a[18:1]][15:8] = wd[7:0]; else ref_m[a[18:1]][7:0] = wd[7:0];
         end else begin
            ref_m[a[18:1]] = wd[15:0];
            if (sz[1]) ref_m[a[18:1] + 1] = wd[31:16];
         end
      end else begin
         chk(oe_lo == acc * dl && we_lo == 0, "R5 oe cycles", oe_lo, acc * dl);
         chk(lane_bad == 0, "R5 lanes", lane_bad, 0);
         case (sz)
            2'd0:    exp_rd = {24'h0, a[0] ? ref_m[a[18:1]][15:8] : ref_m[a[18:1]][7:0]};
            2'd1:    exp_rd = {16'h0, ref_m[a[18:1]]};
            default: exp_rd = {ref_m[a[18:1] + 1], ref_m[a[18:1]]};
         endcase
         chk(rsp_rdata == exp_rd, "R5 rdata", rsp_rdata, exp_rd);
      end
      chk(ce_hi == acc * int'(cfg_turn), "R7 ce high", ce_hi, acc * int'(cfg_turn));
      chk(rdy_hi == 0 && req_ready, "R8 ready", rdy_hi, 0);
      chk(first_a == 18'(a[18:1]), "R2 first addr", 32'(first_a), 32'(a[18:1]));
      chk(last_a == 18'(a[18:1] + acc - 1), "R2 last addr", 32'(last_a), 32'(a[18:1] + acc - 1));
   endtask

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin mem[i] = 16'h0; ref_m[i] = 16'h0; end
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R9 controls",
          {27'h0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'h1f);
      chk(req_ready && !rsp_done && rsp_rdata == 0 && mem_dq === 16'hzzzz, "R9 idle",
          rsp_rdata, 0);
      rst_n = 1'b1;
      for (int ci = 0; ci < 3; ci++) begin
         case (ci)
            0: begin cfg_setup = 4'd3; cfg_hold = 4'd0; cfg_data = 4'd6; cfg_turn = 4'd1; end
            1: begin cfg_setup = 4'd0; cfg_hold = 4'd2; cfg_data = 4'd1; cfg_turn = 4'd0; end
            default: begin cfg_setup = 4'd1; cfg_hold = 4'd1; cfg_data = 4'd0; cfg_turn = 4'd2; end
         endcase
         for (int a = 0; a < 32; a += 4)
            xfer(1'b1, 2'd2, 19'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101) ^ (32'(ci) << 28));
         for (int a = 0; a < 8; a++)
            xfer(1'b1, 2'd0, 19'(a), 32'(8'h30 + 8'(a) + 8'(ci * 16)));
         for (int a = 8; a < 12; a += 2)
            xfer(1'b1, 2'd1, 19'(a), 32'(16'hC000 + 16'(a * 3) + 16'(ci)));
         for (int a = 0; a < 16; a++) xfer(1'b0, 2'd0, 19'(a), 32'h0);
         for (int a = 0; a < 16; a += 2) xfer(1'b0, 2'd1, 19'(a), 32'h0);
         for (int a = 0; a < 16; a += 4) xfer(1'b0, (a == 4) ? 2'd3 : 2'd2, 19'(a), 32'h0);
      end
      @(negedge clk);
      chk(!rsp_done, "R8 done width", 32'(rsp_done), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule